// File: doc/BRIEF.md
# Baud Tick Generator with Selectable Reference

This block produces the bit-rate timing pulse for a serial port. The pulse rate comes from a programmable divide-by-(N+1) counter fed by a fixed prescaler. The prescaler's input is one of two references. The first is the peripheral path, which advances on every system clock. The second is the crystal path, which advances only on cycles where a crystal-derived clock enable is high.

A 32-bit configuration word is loaded from a register input with a one-cycle write strobe. The word carries the divisor, a "divisor in use" flag, the reference select and a crystal prescale select. Software picks N as round(reference / prescale / baud) − 1, for bit rates from 50 to 4,000,000. Each write restarts both counters, so the first pulse after a write arrives one full period later. The output pulse lasts one system clock cycle. A framer that oversamples can program N for its oversample rate.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the configuration is all zeros, and `tick` stays low until a configuration word with bit 23 set is written.
- R2: While the loaded word has bit 23 clear, `tick` is held low and both counters stay at zero, whatever the other bits and `xtal_en` do.
- R3: With bit 23 set and bit 24 clear (peripheral path), `tick` pulses once every 4·(N+1) system clock cycles, where N is bits [22:0] of the word.
- R4: With bits 23 and 24 set and bit 27 clear (crystal path), `tick` pulses once every 3·(N+1) cycles in which `xtal_en` is high.
- R5: With bits 23, 24 and 27 set, `tick` pulses once every 2·(N+1) cycles in which `xtal_en` is high.
- R6: On the peripheral path bit 27 has no effect; the period stays 4·(N+1).
- R7: A write (`cfg_wr` high at a clock edge) clears both counters at that edge and forces `tick` low in the next cycle. The source enable present at the write edge is not counted. The first pulse follows the P·(N+1)-th counted source enable after the write, where P is the prescale ratio.
- R8: `tick` is never high for two cycles in a row.
- R9: With N = 0 the output pulses on every P-th counted source enable.
- R10: On the peripheral path `xtal_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe that loads `cfg_word` and restarts the counters |
| cfg_word | input | 32 | Configuration: [22:0] divisor N, 23 divisor in use, 24 crystal path, 27 crystal prescale by 2 instead of 3 |
| xtal_en | input | 1 | Clock enable derived from the crystal reference |
| tick | output | 1 | One-cycle bit-rate pulse |

## Verification
The embedded properties check several things on every cycle: the output stays low while the divisor is unused, a write is always followed by a low cycle, pulses never come back to back, both counters stay within their programmed limits, and the prescaler holds still on cycles without a source enable. Other behaviour depends on counting across many cycles and only the bench scenarios can show it. This covers the exact period for each reference and prescale choice, the latency from a write to the first pulse, the insensitivity of the peripheral path to `xtal_en` and to bit 27, and the N = 0 edge case. The bench checks these against a cycle-level model that it runs next to the design.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Prescale ratio chosen by the reference and halving flags.
  function automatic int unsigned pick_ratio(input logic xtal_sel, input logic half_sel,
                                             input int unsigned peri_div,
                                             input int unsigned xtal_div,
                                             input int unsigned xtal_half_div);
    if (!xtal_sel) return peri_div;
    return half_sel ? xtal_half_div : xtal_div;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int CFG_W    = 32,
  parameter int DIV_W    = 23,
  parameter int USE_BIT  = 23,
  parameter int XTAL_BIT = 24,
  parameter int HALF_BIT = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] word,
  output logic [DIV_W-1:0] div_n,
  output logic             use_div,
  output logic             xtal_sel,
  output logic             half_sel
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (wr) cfg_q <= word;
  end

  assign div_n    = cfg_q[DIV_W-1:0];
  assign use_div  = cfg_q[USE_BIT];
  assign xtal_sel = cfg_q[XTAL_BIT];
  assign half_sel = cfg_q[HALF_BIT];

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             src_en,
  input  logic [PRE_W-1:0] ratio,
  output logic             pre_fire
);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_last;

  assign pre_last = ratio - 1'b1;
  assign pre_fire = src_en && !clear && (pre_cnt == pre_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (clear)  pre_cnt <= '0;
    else if (src_en) pre_cnt <= (pre_cnt == pre_last) ? '0 : pre_cnt + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt < ratio); // R3
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_en && !clear) |=> $stable(pre_cnt)); // R4
  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_cnt == '0)); // R2

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int DIV_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             wrap,
  output logic             tick_q
);

  logic [DIV_W-1:0] div_cnt;

  assign wrap = step && (div_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= wrap && !clear;
      if (clear)     div_cnt <= '0;
      else if (step) div_cnt <= (div_cnt == limit) ? '0 : div_cnt + 1'b1;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (div_cnt <= limit)); // R7
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R8
  AST_TICK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(step)); // R9

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CFG_W         = 32,
  parameter int DIV_W         = 23,
  parameter int USE_BIT       = 23,
  parameter int XTAL_BIT      = 24,
  parameter int HALF_BIT      = 27,
  parameter int PERI_DIV      = 4,
  parameter int XTAL_DIV      = 3,
  parameter int XTAL_HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             xtal_en,
  output logic             tick
);
  import baud_gen_pkg::*;

  localparam int unsigned MAX_DIV = max3(PERI_DIV, XTAL_DIV, XTAL_HALF_DIV);
  localparam int PRE_W = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] div_n;
  logic             use_div, xtal_sel, half_sel;
  logic             restart, hold_clear, src_en, pre_fire, wrap;
  logic [PRE_W-1:0] ratio;

  baud_cfg_reg #(
    .CFG_W(CFG_W), .DIV_W(DIV_W), .USE_BIT(USE_BIT),
    .XTAL_BIT(XTAL_BIT), .HALF_BIT(HALF_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .word(cfg_word),
    .div_n(div_n), .use_div(use_div), .xtal_sel(xtal_sel), .half_sel(half_sel)
  );

  assign restart    = cfg_wr;
  assign hold_clear = restart || !use_div;
  assign src_en     = xtal_sel ? xtal_en : 1'b1;
  assign ratio      = PRE_W'(pick_ratio(xtal_sel, half_sel, PERI_DIV, XTAL_DIV, XTAL_HALF_DIV));

  baud_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(hold_clear), .src_en(src_en),
    .ratio(ratio), .pre_fire(pre_fire)
  );

  baud_div_counter #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(hold_clear), .step(pre_fire),
    .limit(div_n), .wrap(wrap), .tick_q(tick)
  );

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !use_div |-> !tick); // R2
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick); // R7
  AST_PERI_IGNORES_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_sel |-> src_en); // R10
  AST_WRAP_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !restart) |=> tick); // R3

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        xtal_en = 1'b0;
  logic        tick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] m_word = '0;
  int          m_cnt  = 0;
  logic        prev_tick = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .xtal_en(xtal_en), .tick(tick)
  );

  function automatic int ratio_of(input logic [31:0] w);
    if (!w[24]) return 4;
    return w[27] ? 2 : 3;
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    if (!w[23]) return "R2";
    if (!w[24]) return "R3";
    return w[27] ? "R5" : "R4";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Drive one cycle, then compare the output with the bench model.
  task automatic step(input logic wr, input logic [31:0] w, input logic xe);
    logic exp;
    logic en;
    cfg_wr = wr; cfg_word = w; xtal_en = xe;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    exp = 1'b0;
    if (wr) begin
      m_word = w;
      m_cnt  = 0;
    end else if (m_word[23]) begin
      en = m_word[24] ? xe : 1'b1;
      if (en) begin
        m_cnt++;
        if (m_cnt == ratio_of(m_word) * (int'(m_word[22:0]) + 1)) begin
          m_cnt = 0;
          exp = 1'b1;
        end
      end
    end
    check(wr ? "R7" : tag_of(m_word), int'(tick), int'(exp));
    if (tick) check("R8", int'(prev_tick), 0);
    prev_tick = tick;
  endtask

  function automatic logic xgen(input int mode);
    case (mode)
      0: return 1'b1;
      1: return 1'($urandom_range(0, 1));
      default: return ($urandom_range(0, 2) == 0);
    endcase
  endfunction

  // Write a word and count cycles up to the first pulse.
  task automatic latency(input logic [31:0] w, input int xmode, input int exp, input string req);
    int n;
    n = 0;
    step(1'b1, w, xgen(xmode));
    while (n < 1000) begin
      step(1'b0, w, xgen(xmode));
      n++;
      if (tick) break;
    end
    check(req, n, exp);
  endtask

  task automatic run(input logic [31:0] w, input int xmode, input int len);
    for (int i = 0; i < len; i++) step(1'b0, w, xgen(xmode));
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_up();
      end
    end
  end

  initial begin
    int tcount;
    logic [31:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, no pulse without a written word
    check("R1", int'(tick), 0);
    tcount = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, '0, xgen(1));
      if (tick) tcount++;
    end
    check("R1", tcount, 0);

    // R2: divisor not in use, other bits set
    w = 32'h0900_0000;
    step(1'b1, w, 1'b1);
    tcount = 0;
    for (int i = 0; i < 60; i++) begin
      step(1'b0, w, xgen(0));
      if (tick) tcount++;
    end
    check("R2", tcount, 0);

    // R9: N = 0 on each path
    latency(32'h0080_0000, 0, 4, "R9");
    latency(32'h0180_0000, 0, 3, "R9");
    latency(32'h0980_0000, 0, 2, "R9");
    // R4 / R5 crystal periods with xtal_en always high
    latency(32'h0180_0006, 0, 21, "R4");
    latency(32'h0980_0006, 0, 14, "R5");
    // R6: bit 27 on the peripheral path
    latency(32'h0880_0004, 0, 20, "R6");
    // R10: random xtal_en on the peripheral path
    latency(32'h0080_0005, 1, 24, "R10");
    // R3: plain peripheral period, steady run
    latency(32'h0080_0002, 0, 12, "R3");
    run(32'h0080_0002, 0, 36);
    // R7: rewrite in mid-period restarts the count
    step(1'b1, 32'h0080_0005, 1'b1);
    run(32'h0080_0005, 0, 10);
    latency(32'h0080_0005, 0, 24, "R7");

    // Random configurations against the model
    for (int k = 0; k < 60; k++) begin
      w = $urandom();
      w[22:0] = 23'($urandom_range(0, 12));
      if ($urandom_range(0, 5) != 0) w[23] = 1'b1;
      step(1'b1, w, xgen(1));
      run(w, $urandom_range(0, 2), 40 + 3 * ratio_of(w) * (int'(w[22:0]) + 1) * 3);
    end
    finish_up();
  end
endmodule